// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is the data mover behind a multi-channel DMA controller. Channel registers (source address, destination address, next-descriptor pointer, control word, configuration word) live in the engine. The neighbouring register interface loads them through a simple write port. The engine picks one eligible channel, moves one element per service, and updates that channel's addresses and remaining count. Each move is a read from the source followed by a write to the destination, over a single-beat memory port with a valid/ready handshake.

When a channel's count runs out, the engine looks at the channel's next-descriptor pointer. If the pointer is non-zero, it fetches a four-word descriptor from memory and continues with the new values. If the pointer is zero, it disables the channel. The engine raises per-channel terminal-count and error status bits, and software clears these with one-cycle pulses. Peripheral request lines gate a channel according to its flow type, so a peripheral that stops requesting pauses the channel without losing its state.

Top module: `lli_dma_engine`

## Requirements
- R1: No memory transaction starts while `glob_en_i` is low. Programmed channels keep their enable bit during that time.
- R2: A channel is considered only when configuration bit 0 (enable) is 1 and bit 18 (halt) is 0.
- R3: Configuration bits 13:11 give the flow type, bits 5:1 the source peripheral and bits 10:6 the destination peripheral. The request vector is `req_single_i | req_burst_i`. The gating by flow type is:
  - type 0 always moves;
  - type 1 needs the destination's request bit;
  - type 2 needs the source's request bit;
  - type 3 needs both bits.
- R4: A channel whose count (control bits 11:0) is zero is skipped and stays enabled.
- R5: An element is one read at the source address with `mem_size_o` = control[19:18], then one write at the destination address with `mem_size_o` = control[22:21] and the read data. While `mem_valid_o` waits for `mem_ready_i`, the address and direction hold.
- R6: After each element, the source address advances by 1<<control[20:18] bytes if control bit 26 is set, and the destination address advances by 1<<control[23:21] bytes if control bit 27 is set. Otherwise the address stays fixed.
- R7: The count decrements after each element. When it reaches zero and the pointer is zero, configuration bit 0 clears.
- R8: When the count reaches zero and the pointer is non-zero, the engine reads four words at pointer+0, +4, +8 and +12. These load, in that order, the source address, the destination address, the next pointer and the control word.
- R9: When a count completes, `tc_raw_o[c]` sets if bit 31 of the channel's control word is 1, using the reloaded word when a descriptor was fetched. `tc_clr_i[c]` clears it.
- R10: The following set `err_raw_o[c]` and clear the channel's enable, and `err_clr_i[c]` clears the error bit:
  - a flow type above 3;
  - a width code above 2;
  - `mem_err_i` on any handshake.
- R11: The lowest-index eligible channel is chosen. A channel that still has eligible work keeps being served before any other channel is chosen.
- R12: A channel whose flow gate drops mid-count pauses, then resumes with its count and addresses intact.
- R13: After reset, all enables and status bits are 0 and `mem_valid_o` is low.
- R14: `reg_sel_i` selects the register written on `reg_we_i`: 0 source, 1 destination, 2 next pointer, 3 control, 4 configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| glob_en_i | input | 1 | Global engine enable |
| req_single_i | input | 32 | Single-request lines per peripheral |
| req_burst_i | input | 32 | Burst-request lines per peripheral |
| reg_we_i | input | 1 | Channel register write strobe |
| reg_ch_i | input | CH_W | Channel index of the write |
| reg_sel_i | input | 3 | Register select (R14) |
| reg_wdata_i | input | 32 | Write data |
| tc_clr_i | input | NUM_CH | Terminal-count status clear pulses |
| err_clr_i | input | NUM_CH | Error status clear pulses |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts/completes the request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 32 | Byte address |
| mem_size_o | output | 2 | log2 of bytes in the beat |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_err_i | input | 1 | Error response, valid with ready |
| chan_en_o | output | NUM_CH | Per-channel enable bits |
| tc_raw_o | output | NUM_CH | Raw terminal-count status |
| err_raw_o | output | NUM_CH | Raw error status |

## Verification
A wrong address or count register shows up at the very next memory beat of that channel: the address is off, or there is an extra or a missing beat before the enable drops. A broken descriptor fetch shows in the four fetch addresses and in the addresses of the elements that follow it. Scheduling faults show in the order of destination addresses within a few beats. Flow-gating faults show as a beat that appears or does not appear within a few tens of cycles after a request pattern is applied.

// File: rtl/lli_dma_pkg.sv
package lli_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_LLI} st_e;

  localparam int CF_EN   = 0;
  localparam int CF_HALT = 18;
  localparam int CT_SINC = 26;
  localparam int CT_DINC = 27;
  localparam int CT_TC   = 31;
  localparam int CNT_W   = 12;

  function automatic logic flow_ok(input logic [2:0] flow, input logic [31:0] req,
                                   input logic [4:0] sp, input logic [4:0] dp);
    case (flow)
      3'd0:    return 1'b1;
      3'd1:    return req[dp];
      3'd2:    return req[sp];
      3'd3:    return req[sp] & req[dp];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lli_dma_elig.sv
module lli_dma_elig import lli_dma_pkg::*; #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0][31:0] conf_i,
  input  logic [NUM_CH-1:0][31:0] ctrl_i,
  input  logic [31:0]             req_i,
  output logic [NUM_CH-1:0]       work_o,
  output logic [NUM_CH-1:0]       bad_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic live;
    logic [2:0] flow;
    assign live = conf_i[g][CF_EN] & ~conf_i[g][CF_HALT];
    assign flow = conf_i[g][13:11];
    assign bad_o[g] = live & ((flow > 3'd3) | (ctrl_i[g][20:18] > 3'd2) |
                              (ctrl_i[g][23:21] > 3'd2));
    assign work_o[g] = live & ~bad_o[g] & (ctrl_i[g][CNT_W-1:0] != '0) &
                       flow_ok(flow, req_i, conf_i[g][5:1], conf_i[g][10:6]);
  end
endmodule

// File: rtl/lli_dma_prio.sv
module lli_dma_prio #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              hold_i,
  input  logic [CH_W-1:0]   cur_i,
  output logic [CH_W-1:0]   idx_o,
  output logic              any_o
);
  logic [CH_W-1:0] low;
  always_comb begin
    low = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (req_i[i]) low = CH_W'(i);
  end
  assign any_o = |req_i;
  assign idx_o = (hold_i && req_i[cur_i]) ? cur_i : low;

  assert_pick_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> req_i[idx_o]);
  assert_pick_lowest_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_o && !(hold_i && req_i[cur_i])) |-> ((req_i & ((NUM_CH'(1) << idx_o) - NUM_CH'(1))) == '0));
endmodule

// File: rtl/lli_dma_engine.sv
module lli_dma_engine import lli_dma_pkg::*; #(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              glob_en_i,
  input  logic [31:0]       req_single_i,
  input  logic [31:0]       req_burst_i,
  input  logic              reg_we_i,
  input  logic [CH_W-1:0]   reg_ch_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [NUM_CH-1:0] tc_clr_i,
  input  logic [NUM_CH-1:0] err_clr_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_err_i,
  output logic [NUM_CH-1:0] chan_en_o,
  output logic [NUM_CH-1:0] tc_raw_o,
  output logic [NUM_CH-1:0] err_raw_o
);
  logic [NUM_CH-1:0][31:0] src_q, dst_q, lli_q, ctrl_q, conf_q;
  logic [NUM_CH-1:0] tc_q, err_q, work, bad, cand;
  logic [CH_W-1:0] cur_q, pick;
  logic hold_q, any, hs;
  logic [31:0] buf_q, base_q, ctrl_cur;
  logic [1:0] k_q;
  logic [CNT_W-1:0] cnt_cur;
  st_e st_q;

  lli_dma_elig #(.NUM_CH(NUM_CH)) u_elig (
    .conf_i(conf_q), .ctrl_i(ctrl_q), .req_i(req_single_i | req_burst_i),
    .work_o(work), .bad_o(bad));

  assign cand = glob_en_i ? (work | bad) : '0;

  lli_dma_prio #(.NUM_CH(NUM_CH)) u_prio (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(cand), .hold_i(hold_q),
    .cur_i(cur_q), .idx_o(pick), .any_o(any));

  assign ctrl_cur    = ctrl_q[cur_q];
  assign cnt_cur     = ctrl_cur[CNT_W-1:0];
  assign mem_valid_o = (st_q != ST_IDLE);
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_wdata_o = buf_q;
  assign hs          = mem_valid_o & mem_ready_i;

  always_comb begin
    case (st_q)
      ST_RD:   begin mem_addr_o = src_q[cur_q]; mem_size_o = ctrl_cur[19:18]; end
      ST_WR:   begin mem_addr_o = dst_q[cur_q]; mem_size_o = ctrl_cur[22:21]; end
      ST_LLI:  begin mem_addr_o = base_q + {28'd0, k_q, 2'b00}; mem_size_o = 2'd2; end
      default: begin mem_addr_o = '0; mem_size_o = '0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; dst_q <= '0; lli_q <= '0; ctrl_q <= '0; conf_q <= '0;
      tc_q <= '0; err_q <= '0; cur_q <= '0; hold_q <= 1'b0;
      buf_q <= '0; base_q <= '0; k_q <= '0; st_q <= ST_IDLE;
    end else begin
      tc_q  <= tc_q & ~tc_clr_i;
      err_q <= err_q & ~err_clr_i;
      case (st_q)
        ST_IDLE: begin
          if (any) begin
            cur_q <= pick;
            if (bad[pick]) begin
              err_q[pick]         <= 1'b1;
              conf_q[pick][CF_EN] <= 1'b0;
              hold_q              <= 1'b0;
            end else st_q <= ST_RD;
          end else hold_q <= 1'b0;
        end
        ST_RD: if (hs) begin
          if (mem_err_i) begin
            err_q[cur_q] <= 1'b1; conf_q[cur_q][CF_EN] <= 1'b0; hold_q <= 1'b0; st_q <= ST_IDLE;
          end else begin
            buf_q <= mem_rdata_i; st_q <= ST_WR;
          end
        end
        ST_WR: if (hs) begin
          st_q <= ST_IDLE;
          if (mem_err_i) begin
            err_q[cur_q] <= 1'b1; conf_q[cur_q][CF_EN] <= 1'b0; hold_q <= 1'b0;
          end else begin
            hold_q <= 1'b1;
            if (ctrl_cur[CT_SINC]) src_q[cur_q] <= src_q[cur_q] + (32'd1 << ctrl_cur[20:18]);
            if (ctrl_cur[CT_DINC]) dst_q[cur_q] <= dst_q[cur_q] + (32'd1 << ctrl_cur[23:21]);
            ctrl_q[cur_q][CNT_W-1:0] <= cnt_cur - 1'b1;
            if (cnt_cur == CNT_W'(1)) begin
              if (lli_q[cur_q] != '0) begin
                base_q <= lli_q[cur_q]; k_q <= '0; st_q <= ST_LLI;
              end else begin
                conf_q[cur_q][CF_EN] <= 1'b0;
                if (ctrl_cur[CT_TC]) tc_q[cur_q] <= 1'b1;
              end
            end
          end
        end
        ST_LLI: if (hs) begin
          if (mem_err_i) begin
            err_q[cur_q] <= 1'b1; conf_q[cur_q][CF_EN] <= 1'b0; hold_q <= 1'b0; st_q <= ST_IDLE;
          end else begin
            k_q <= k_q + 1'b1;
            case (k_q)
              2'd0: src_q[cur_q] <= mem_rdata_i;
              2'd1: dst_q[cur_q] <= mem_rdata_i;
              2'd2: lli_q[cur_q] <= mem_rdata_i;
              default: begin
                ctrl_q[cur_q] <= mem_rdata_i;
                if (mem_rdata_i[CT_TC]) tc_q[cur_q] <= 1'b1;
                st_q <= ST_IDLE;
              end
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      if (reg_we_i) begin
        case (reg_sel_i)
          3'd0: src_q[reg_ch_i]  <= reg_wdata_i;
          3'd1: dst_q[reg_ch_i]  <= reg_wdata_i;
          3'd2: lli_q[reg_ch_i]  <= reg_wdata_i;
          3'd3: ctrl_q[reg_ch_i] <= reg_wdata_i;
          3'd4: conf_q[reg_ch_i] <= reg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_en
    assign chan_en_o[g] = conf_q[g][CF_EN];
  end
  assign tc_raw_o  = tc_q;
  assign err_raw_o = err_q;

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  assert_glob_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glob_en_i && st_q == ST_IDLE) |=> !mem_valid_o);
  assert_err_disable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && mem_err_i && !reg_we_i) |=> (err_raw_o[cur_q] && !chan_en_o[cur_q]));
  assert_cnt_dec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR && hs && !mem_err_i && !reg_we_i) |=> (cnt_cur == $past(cnt_cur) - 1'b1));
endmodule

// File: tb/lli_dma_engine_tb_top.sv
module lli_dma_engine_tb_top;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic glob_en = 1'b0;
  logic [31:0] rs = '0, rb = '0;
  logic reg_we = 1'b0; logic [1:0] reg_ch = '0; logic [2:0] reg_sel = '0; logic [31:0] reg_wd = '0;
  logic [N-1:0] tc_clr = '0, err_clr = '0;
  logic mvalid, mready = 1'b0, mwe, merr = 1'b0;
  logic [31:0] maddr, mwdata, mrdata = '0;
  logic [1:0] msize;
  logic [N-1:0] en, tc, er;

  lli_dma_engine #(.NUM_CH(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .glob_en_i(glob_en), .req_single_i(rs), .req_burst_i(rb),
    .reg_we_i(reg_we), .reg_ch_i(reg_ch), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wd),
    .tc_clr_i(tc_clr), .err_clr_i(err_clr), .mem_valid_o(mvalid), .mem_ready_i(mready),
    .mem_we_o(mwe), .mem_addr_o(maddr), .mem_size_o(msize), .mem_wdata_o(mwdata),
    .mem_rdata_i(mrdata), .mem_err_i(merr), .chan_en_o(en), .tc_raw_o(tc), .err_raw_o(er));

  int checks = 0, errors = 0;
  logic [31:0] desc [4];
  logic [31:0] la [256]; logic [31:0] ld [256]; logic lw [256]; logic [1:0] ls [256];
  int log_n = 0, sc = 0;

  function automatic logic [31:0] rd_fn(input logic [31:0] a);
    if (a >= 32'h300 && a <= 32'h30C) return desc[(a - 32'h300) >> 2];
    return a ^ 32'hA5A5_0000;
  endfunction

  always @(negedge clk) begin
    mready <= 1'b0; merr <= 1'b0;
    if (rst_n && mvalid) begin
      sc++;
      if (sc % 3 != 2 && log_n < 256) begin
        mready <= 1'b1; merr <= maddr[31]; mrdata <= rd_fn(maddr);
        la[log_n] = maddr; ld[log_n] = mwdata; lw[log_n] = mwe; ls[log_n] = msize;
        log_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask
  task automatic wreg(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_ch = 2'(ch); reg_sel = 3'(sel); reg_wd = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic clr_all();
    @(negedge clk); tc_clr = '1; err_clr = '1; @(negedge clk); tc_clr = '0; err_clr = '0;
  endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask
  function automatic logic [31:0] mk_ctrl(bit t, bit di, bit si, logic [2:0] dw, logic [2:0] sw, logic [11:0] n);
    return {t, 3'b0, di, si, 2'b0, dw, sw, 6'b0, n};
  endfunction
  function automatic logic [31:0] mk_conf(bit e, bit h, logic [2:0] f, logic [4:0] sp, logic [4:0] dp);
    return {13'b0, h, 4'b0, f, dp, sp, e};
  endfunction
  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d, input logic [31:0] l,
                      input logic [31:0] c, input logic [31:0] f);
    wreg(ch, 0, s); wreg(ch, 1, d); wreg(ch, 2, l); wreg(ch, 3, c); wreg(ch, 4, f);
  endtask
  function automatic int nw(input int st);
    int c = 0;
    for (int i = st; i < log_n; i++) if (lw[i]) c++;
    return c;
  endfunction
  task automatic chk_t(input int i, input bit we, input logic [31:0] a, input string tag);
    chk(i < log_n && lw[i] == we && la[i] == a, tag, (i < log_n) ? la[i] : 32'hDEAD, a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; $display("FAIL watchdog act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int st;
    desc[0] = 32'h140; desc[1] = 32'h240; desc[2] = 32'h0; desc[3] = mk_ctrl(1, 1, 1, 2, 2, 2);
    idle(3); rst_n = 1'b1; idle(2);
    // R13 reset state
    chk(en == 0 && tc == 0 && er == 0 && !mvalid, "R13 reset", {en, tc, er}, 0);

    // R1 global gate, R14 register select
    st = log_n;
    prog(0, 32'h100, 32'h200, 0, mk_ctrl(1, 1, 1, 2, 2, 3), mk_conf(1, 0, 0, 0, 0));
    idle(30);
    chk(log_n == st && en[0], "R1 gated", log_n - st, 0);
    glob_en = 1'b1; idle(60);
    // R5 R6 R7 R9 main run
    chk(log_n - st == 6, "R7 three elements", log_n - st, 6);
    for (int i = 0; i < 3; i++) begin
      chk_t(st + 2 * i, 0, 32'h100 + 4 * i, "R6 src addr");
      chk_t(st + 2 * i + 1, 1, 32'h200 + 4 * i, "R6 dst addr");
      chk(ld[st + 2 * i + 1] == ((32'h100 + 4 * i) ^ 32'hA5A5_0000), "R5 data",
          ld[st + 2 * i + 1], (32'h100 + 4 * i) ^ 32'hA5A5_0000);
    end
    chk(!en[0] && tc[0], "R9 tc and R7 disable", {en[0], tc[0]}, 2'b01);
    clr_all();
    chk(tc == 0, "R9 clear", tc, 0);

    // R6 fixed addresses, R9 no tc when bit31 clear
    st = log_n;
    prog(1, 32'h120, 32'h220, 0, mk_ctrl(0, 0, 0, 2, 2, 2), mk_conf(1, 0, 0, 0, 0));
    idle(50);
    chk_t(st, 0, 32'h120, "R6 fixed src"); chk_t(st + 2, 0, 32'h120, "R6 fixed src2");
    chk_t(st + 3, 1, 32'h220, "R6 fixed dst2");
    chk(!en[1] && !tc[1], "R9 no tc", {en[1], tc[1]}, 0);

    // R6 halfword width
    st = log_n;
    prog(0, 32'h100, 32'h200, 0, mk_ctrl(0, 1, 1, 1, 1, 2), mk_conf(1, 0, 0, 0, 0));
    idle(50);
    chk_t(st + 2, 0, 32'h102, "R6 half src"); chk_t(st + 3, 1, 32'h202, "R6 half dst");
    chk(ls[st] == 2'd1 && ls[st + 1] == 2'd1, "R5 size", {ls[st], ls[st + 1]}, 4'b0101);

    // R2 halt
    st = log_n;
    prog(2, 32'h100, 32'h200, 0, mk_ctrl(0, 1, 1, 2, 2, 1), mk_conf(1, 1, 0, 0, 0));
    idle(30);
    chk(log_n == st, "R2 halted", log_n - st, 0);
    wreg(2, 4, mk_conf(1, 0, 0, 0, 0)); idle(30);
    chk(nw(st) == 1, "R2 released", nw(st), 1);

    // R4 zero count
    st = log_n;
    prog(3, 32'h100, 32'h200, 0, mk_ctrl(0, 1, 1, 2, 2, 0), mk_conf(1, 0, 0, 0, 0));
    idle(30);
    chk(log_n == st && en[3], "R4 zero count", {log_n - st}, 0);
    wreg(3, 4, 0);

    // R3 flow sweep: src periph 5 on single, dst periph 9 on burst
    for (int f = 1; f <= 3; f++)
      for (int p = 0; p < 4; p++) begin
        bit exp_mv;
        exp_mv = (f == 1) ? p[1] : (f == 2) ? p[0] : (p[0] & p[1]);
        st = log_n;
        rs = p[0] ? (32'd1 << 5) : 0; rb = p[1] ? (32'd1 << 9) : 0;
        prog(3, 32'h180, 32'h380, 0, mk_ctrl(0, 1, 1, 2, 2, 1), mk_conf(1, 0, 3'(f), 5, 9));
        idle(30);
        chk(nw(st) == int'(exp_mv), $sformatf("R3 flow %0d req %0d", f, p), nw(st), exp_mv);
        wreg(3, 4, 0); rs = 0; rb = 0;
      end

    // R12 pause and resume
    st = log_n; rs = 32'd1 << 5;
    prog(0, 32'h100, 32'h200, 0, mk_ctrl(0, 1, 1, 2, 2, 3), mk_conf(1, 0, 2, 5, 9));
    while (nw(st) < 1) @(negedge clk);
    rs = 0; idle(40);
    chk(nw(st) == 1 && en[0], "R12 paused", nw(st), 1);
    rb = 32'd1 << 5; idle(60);
    chk(nw(st) == 3 && !en[0], "R12 resumed", nw(st), 3);
    chk_t(log_n - 1, 1, 32'h208, "R12 dst continues");
    chk_t(log_n - 2, 0, 32'h108, "R12 src continues");
    rb = 0;

    // R8 linked-list reload, R9 tc from reloaded control
    clr_all(); st = log_n;
    prog(1, 32'h180, 32'h1C0, 32'h300, mk_ctrl(0, 1, 1, 2, 2, 1), mk_conf(1, 0, 0, 0, 0));
    idle(80);
    chk(log_n - st == 10, "R8 beat count", log_n - st, 10);
    for (int k = 0; k < 4; k++) chk_t(st + 2 + k, 0, 32'h300 + 4 * k, "R8 fetch order");
    chk_t(st + 6, 0, 32'h140, "R8 new src"); chk_t(st + 7, 1, 32'h240, "R8 new dst");
    chk_t(st + 9, 1, 32'h244, "R8 second element");
    chk(tc[1] && !en[1], "R9 reloaded tc", {tc[1], en[1]}, 2'b10);

    // R10 errors
    st = log_n;
    prog(2, 32'h100, 32'h200, 0, mk_ctrl(0, 1, 1, 2, 2, 1), mk_conf(1, 0, 5, 0, 0));
    idle(20);
    chk(log_n == st && er[2] && !en[2], "R10 bad flow", {er[2], en[2]}, 2'b10);
    clr_all();
    chk(er == 0, "R10 err clear", er, 0);
    prog(2, 32'h100, 32'h200, 0, mk_ctrl(0, 1, 1, 2, 3, 1), mk_conf(1, 0, 0, 0, 0));
    idle(20);
    chk(log_n == st && er[2] && !en[2], "R10 bad width", {er[2], en[2]}, 2'b10);
    clr_all();
    prog(2, 32'h8000_0100, 32'h200, 0, mk_ctrl(0, 1, 1, 2, 2, 2), mk_conf(1, 0, 0, 0, 0));
    idle(30);
    chk(log_n - st == 1 && er[2] && !en[2], "R10 mem error", log_n - st, 1);
    clr_all();

    // R11 lowest index first, then sticky service
    glob_en = 1'b0; st = log_n;
    prog(2, 32'h100, 32'h280, 0, mk_ctrl(0, 1, 1, 2, 2, 2), mk_conf(1, 0, 0, 0, 0));
    prog(1, 32'h100, 32'h2C0, 0, mk_ctrl(0, 1, 1, 2, 2, 2), mk_conf(1, 0, 0, 0, 0));
    glob_en = 1'b1; idle(60);
    chk_t(st + 1, 1, 32'h2C0, "R11 low first"); chk_t(st + 3, 1, 32'h2C4, "R11 low again");
    chk_t(st + 5, 1, 32'h280, "R11 then higher");
    st = log_n;
    prog(2, 32'h100, 32'h280, 0, mk_ctrl(0, 1, 1, 2, 2, 3), mk_conf(1, 0, 0, 0, 0));
    while (log_n == st) @(negedge clk);
    wreg(0, 3, mk_ctrl(0, 1, 1, 2, 2, 1)); wreg(0, 1, 32'h2E0); wreg(0, 4, mk_conf(1, 0, 0, 0, 0));
    idle(60);
    chk_t(st + 5, 1, 32'h288, "R11 sticky"); chk_t(st + 7, 1, 32'h2E0, "R11 lower after");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule